// File: doc/BRIEF.md
# Thermistor Temperature-Rise Rate Detector

This block watches the voltage of a negative-coefficient thermistor during fast charge and raises a termination flag when the battery warms too quickly. Because the thermistor voltage falls as temperature climbs, a fast rise shows up as a voltage drop between periodic samples. Charge-control logic pulses `sample_strobe` once per sampling period, nominally every 34 s. The block then collects a burst of `NCONV` ADC conversions over a valid/ready stream and reduces them to one averaged sample.

Each averaged sample is compared with the sample taken two periods earlier, not with the previous one. The comparison counts only when four conditions hold: two earlier samples exist since the last cycle start, the new sample lies strictly between the cutoff code and the low-fault code, and the fast-charge hold-off flag is low. Every sample enters the two-deep history, including masked ones. Once raised, the trip flag stays high until `cycle_start` begins a new charge cycle. `cycle_start` also empties the history and aborts any burst in progress.

Conversion stream rules: `conv_ready` is high only while a burst is being collected. A conversion is taken on a clock edge where both `conv_valid` and `conv_ready` are high. While `conv_ready` is low the producer is back-pressured: valid codes offered then are neither consumed nor counted.

Top module: `trise_detector`

## Requirements
- R1: After reset, and in the cycle after `cycle_start` is high, `trip`, `conv_ready` and `sample_done` are low and the history holds no samples.
- R2: A `sample_strobe` while idle raises `conv_ready` on the next cycle. `conv_ready` stays high until exactly `NCONV` (default 16) handshakes have completed, and it is low in the cycle after the last one.
- R3: In the cycle after the final handshake of a burst, `sample_done` is high for exactly one cycle and `sample_avg` equals the sum of the burst's codes divided by `NCONV`, rounded down.
- R4: `sample_strobe` during a burst has no effect on the burst, and `conv_valid` while `conv_ready` is low adds nothing to any sample.
- R5: The first and second samples after a cycle start never raise `trip`.
- R6: With two earlier samples present, a new sample raises `trip` on the cycle after `sample_done` when the sample two periods back minus the new sample is at least `DROP_CODE` (default 16). A drop of `DROP_CODE`-1 does not raise `trip`.
- R7: The comparison counts only when `cutoff_code < sample_avg < lowfault_code`. A sample equal to either bound does not trip.
- R8: A sample completed while `hold_off` is high does not raise `trip`.
- R9: Samples masked by hold-off or by the window still enter the history and serve as the reference for the sample two periods later.
- R10: `trip` stays high until `cycle_start`. When `cycle_start` coincides with `sample_done`, the clear wins: that sample neither trips nor enters the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cycle_start | input | 1 | New charge cycle: clears history, burst and trip |
| sample_strobe | input | 1 | Begin collecting one averaged sample |
| conv_valid | input | 1 | Conversion code offered |
| conv_ready | output | 1 | Block accepts conversions (burst active) |
| conv_code | input | CODE_W | Thermistor-voltage ADC code |
| cutoff_code | input | CODE_W | Lower window bound (temperature cutoff) |
| lowfault_code | input | CODE_W | Upper window bound (low-temperature fault) |
| hold_off | input | 1 | Fast-charge hold-off active: comparison masked |
| sample_done | output | 1 | One-cycle pulse: new averaged sample ready |
| sample_avg | output | CODE_W | Latest averaged sample |
| trip | output | 1 | Latched rate-of-rise termination flag |

## Verification
Completion of a sample and a charge-cycle clear can land in the same cycle. In that case the clear must win over both the history push and the trip decision. The bench provokes this by raising `cycle_start` exactly in the `sample_done` cycle after building two samples of history and feeding a dropping burst. It then requires `trip` to stay low, and it requires the next sample to be treated as the first of a new cycle, so a large drop still gives no trip. Randomly timed clears during the random bursts exercise the same collision against a bench model of the history.

// File: rtl/trise_pkg.sv
package trise_pkg;

  typedef enum logic [0:0] {
    BURST_IDLE    = 1'b0,
    BURST_COLLECT = 1'b1
  } burst_state_e;

  // Unsigned difference with borrow flag, used by the rate comparison.
  function automatic logic [16:0] sub_with_borrow(input logic [15:0] a, input logic [15:0] b);
    return {1'b0, a} - {1'b0, b};
  endfunction

endpackage

// File: rtl/burst_avg.sv
module burst_avg
  import trise_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int NCONV  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              strobe,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  output logic              done,
  output logic [CODE_W-1:0] avg
);
  localparam int SH    = $clog2(NCONV);
  localparam int ACC_W = CODE_W + SH;
  localparam int CNT_W = $clog2(NCONV + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NCONV - 1);

  burst_state_e     state;
  logic [ACC_W-1:0] acc;
  logic [CNT_W-1:0] cnt;
  logic             accept;
  logic             last_acc;
  logic [ACC_W-1:0] sum_next;

  assign in_ready = (state == BURST_COLLECT);
  assign accept   = in_valid && in_ready;
  assign last_acc = accept && (cnt == LAST_IDX);
  assign sum_next = acc + ACC_W'(in_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= BURST_IDLE;
      acc   <= '0;
      cnt   <= '0;
      done  <= 1'b0;
      avg   <= '0;
    end else if (clear) begin
      state <= BURST_IDLE;
      acc   <= '0;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        BURST_IDLE: begin
          if (strobe) begin
            state <= BURST_COLLECT;
            acc   <= '0;
            cnt   <= '0;
          end
        end
        BURST_COLLECT: begin
          if (last_acc) begin
            done  <= 1'b1;
            avg   <= sum_next[ACC_W-1:SH];
            state <= BURST_IDLE;
          end else if (accept) begin
            acc <= sum_next;
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= BURST_IDLE;
      endcase
    end
  end

  p_ready_drops_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (last_acc && !clear) |=> (!in_ready && done));

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_burst_continues_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !last_acc && !clear) |=> in_ready);

endmodule

// File: rtl/sample_history.sv
module sample_history #(
  parameter int CODE_W = 10,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic [CODE_W-1:0] din,
  output logic [CODE_W-1:0] oldest,
  output logic              full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CODE_W-1:0] hist [DEPTH];
  logic [CW-1:0]     cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               hist[0] <= '0;
    else if (clear)           hist[0] <= '0;
    else if (push)            hist[0] <= din;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             hist[g] <= '0;
      else if (clear)         hist[g] <= '0;
      else if (push)          hist[g] <= hist[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (clear)                   cnt <= '0;
    else if (push && cnt != FULL_CNT) cnt <= cnt + 1'b1;
  end

  assign oldest = hist[DEPTH-1];
  assign full   = (cnt == FULL_CNT);

  p_full_persists_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clear) |=> full);

  p_clear_empties_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));

endmodule

// File: rtl/rise_compare.sv
module rise_compare
  import trise_pkg::*;
#(
  parameter int CODE_W    = 10,
  parameter int DROP_CODE = 16
) (
  input  logic [CODE_W-1:0] sample,
  input  logic [CODE_W-1:0] ref_code,
  input  logic [CODE_W-1:0] cutoff,
  input  logic [CODE_W-1:0] lowfault,
  input  logic              hold_off,
  input  logic              have_ref,
  output logic              fire
);
  localparam logic [16:0] DROP_W = 17'(DROP_CODE);

  logic        in_window;
  logic [16:0] diff;
  logic        drop_ok;

  assign in_window = (sample > cutoff) && (sample < lowfault);
  assign diff      = sub_with_borrow(16'(ref_code), 16'(sample));
  assign drop_ok   = !diff[16] && (diff >= DROP_W);
  assign fire      = have_ref && !hold_off && in_window && drop_ok;

endmodule

// File: rtl/trise_detector.sv
module trise_detector #(
  parameter int CODE_W    = 10,
  parameter int NCONV     = 16,
  parameter int DEPTH     = 2,
  parameter int DROP_CODE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cycle_start,
  input  logic              sample_strobe,
  input  logic              conv_valid,
  output logic              conv_ready,
  input  logic [CODE_W-1:0] conv_code,
  input  logic [CODE_W-1:0] cutoff_code,
  input  logic [CODE_W-1:0] lowfault_code,
  input  logic              hold_off,
  output logic              sample_done,
  output logic [CODE_W-1:0] sample_avg,
  output logic              trip
);
  logic [CODE_W-1:0] ref_code;
  logic              hist_full;
  logic              fire;

  burst_avg #(.CODE_W(CODE_W), .NCONV(NCONV)) u_avg (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cycle_start),
    .strobe   (sample_strobe),
    .in_valid (conv_valid),
    .in_ready (conv_ready),
    .in_code  (conv_code),
    .done     (sample_done),
    .avg      (sample_avg)
  );

  sample_history #(.CODE_W(CODE_W), .DEPTH(DEPTH)) u_hist (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (cycle_start),
    .push   (sample_done),
    .din    (sample_avg),
    .oldest (ref_code),
    .full   (hist_full)
  );

  rise_compare #(.CODE_W(CODE_W), .DROP_CODE(DROP_CODE)) u_cmp (
    .sample   (sample_avg),
    .ref_code (ref_code),
    .cutoff   (cutoff_code),
    .lowfault (lowfault_code),
    .hold_off (hold_off),
    .have_ref (hist_full),
    .fire     (fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    trip <= 1'b0;
    else if (cycle_start)          trip <= 1'b0;
    else if (sample_done && fire)  trip <= 1'b1;
  end

  p_trip_latched_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && !cycle_start) |=> trip);

  p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> (!trip && !conv_ready && !sample_done));

  p_no_early_trip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_done && !hist_full && !trip) |=> !trip);

  p_hold_masks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_done && hold_off && !trip) |=> !trip);

  p_window_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_done && !trip &&
     ((sample_avg <= cutoff_code) || (sample_avg >= lowfault_code))) |=> !trip);

endmodule

// File: tb/trise_detector_test.sv
module trise_detector_test;
  localparam int CW = 10;
  localparam int NC = 16;
  localparam int DROP = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cycle_start = 1'b0;
  logic          sample_strobe = 1'b0;
  logic          conv_valid = 1'b0;
  logic          conv_ready;
  logic [CW-1:0] conv_code = '0;
  logic [CW-1:0] cutoff_code = 10'd200;
  logic [CW-1:0] lowfault_code = 10'd900;
  logic          hold_off = 1'b0;
  logic          sample_done;
  logic [CW-1:0] sample_avg;
  logic          trip;

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  // bench model
  int  mh0 = 0, mh1 = 0, mcnt = 0;
  bit  mtrip = 1'b0;

  always #2 clk = ~clk;

  trise_detector uut (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .sample_strobe(sample_strobe),
    .conv_valid(conv_valid), .conv_ready(conv_ready), .conv_code(conv_code),
    .cutoff_code(cutoff_code), .lowfault_code(lowfault_code), .hold_off(hold_off),
    .sample_done(sample_done), .sample_avg(sample_avg), .trip(trip)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit model_fire(input int avg);
    return (mcnt == 2) && !hold_off && (avg > int'(cutoff_code)) &&
           (avg < int'(lowfault_code)) && ((mh1 - avg) >= DROP);
  endfunction

  task automatic model_push(input int avg);
    if (model_fire(avg)) mtrip = 1'b1;
    mh1 = mh0;
    mh0 = avg;
    if (mcnt < 2) mcnt++;
  endtask

  task automatic new_cycle(input string tag);
    @(negedge clk) cycle_start = 1'b1;
    @(negedge clk) cycle_start = 1'b0;
    mcnt = 0; mtrip = 1'b0;
    chk(trip == 1'b0, {tag, " R1 trip after start"}, trip, 0);
    chk(conv_ready == 1'b0 && sample_done == 1'b0, {tag, " R1 idle after start"},
        {conv_ready, sample_done}, 0);
  endtask

  // One burst of NC codes in [base, base+spread-1]; clr raises cycle_start in the done cycle.
  task automatic burst(input int base, input int spread, input bit clr, input string tag);
    int sum = 0;
    int ready_ok = 1;
    @(negedge clk) sample_strobe = 1'b1;
    @(negedge clk) sample_strobe = 1'b0;
    for (int i = 0; i < NC; i++) begin
      if (($urandom % 4) == 0) begin
        conv_valid = 1'b0;
        @(negedge clk);
        if (!conv_ready) ready_ok = 0;
      end
      begin
        int c = base + int'($urandom % spread);
        if (c > 1023) c = 1023;
        if (c < 0) c = 0;
        conv_code = c[CW-1:0];
        sum += c;
      end
      conv_valid = 1'b1;
      if (i == 7) sample_strobe = 1'b1;  // mid-burst strobe must be ignored (R4)
      if (!conv_ready) ready_ok = 0;
      @(negedge clk);
      sample_strobe = 1'b0;
    end
    conv_valid = 1'b0;
    chk(ready_ok == 1, {tag, " R2 ready held during burst"}, ready_ok, 1);
    chk(conv_ready == 1'b0, {tag, " R2 ready low after last"}, conv_ready, 0);
    chk(sample_done == 1'b1, {tag, " R3 done pulse"}, sample_done, 1);
    chk(int'(sample_avg) == sum / NC, {tag, " R3 average"}, sample_avg, sum / NC);
    if (clr) begin
      cycle_start = 1'b1;
      mcnt = 0; mtrip = 1'b0;
    end else begin
      model_push(sum / NC);
    end
    @(negedge clk);
    cycle_start = 1'b0;
    chk(sample_done == 1'b0, {tag, " R3 done one cycle"}, sample_done, 0);
    chk(trip == mtrip, {tag, " R6 trip decision"}, trip, mtrip);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(trip == 1'b0 && conv_ready == 1'b0 && sample_done == 1'b0, "R1 reset state",
        {trip, conv_ready, sample_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 / R6: first two never trip, exact drop on third trips, R10 latch
    new_cycle("seq1");
    burst(800, 1, 1'b0, "R5 first");
    burst(500, 1, 1'b0, "R5 second");
    chk(trip == 1'b0, "R5 no trip on two samples", trip, 0);
    burst(784, 1, 1'b0, "R6 exact drop");
    chk(trip == 1'b1, "R6 drop of DROP trips", trip, 1);
    burst(950, 1, 1'b0, "R10 hold latch");
    chk(trip == 1'b1, "R10 trip latched", trip, 1);
    new_cycle("R10 clear");

    // R6: one code short of the threshold
    burst(800, 1, 1'b0, "R6 a");
    burst(800, 1, 1'b0, "R6 b");
    burst(785, 1, 1'b0, "R6 short");
    chk(trip == 1'b0, "R6 drop DROP-1 no trip", trip, 0);

    // R7: window bounds inclusive of neither end
    new_cycle("R7");
    burst(800, 1, 1'b0, "R7 a");
    burst(800, 1, 1'b0, "R7 b");
    cutoff_code = 10'd600;
    burst(600, 1, 1'b0, "R7 at cutoff");
    chk(trip == 1'b0, "R7 sample equal cutoff no trip", trip, 0);
    cutoff_code = 10'd200; lowfault_code = 10'd700;
    burst(700, 1, 1'b0, "R7 at lowfault");
    chk(trip == 1'b0, "R7 sample equal lowfault no trip", trip, 0);
    lowfault_code = 10'd900;

    // R8 / R9: masked samples are stored and later act as reference
    new_cycle("R8");
    hold_off = 1'b1;
    burst(800, 1, 1'b0, "R8 a");
    burst(800, 1, 1'b0, "R8 b");
    burst(400, 1, 1'b0, "R8 masked drop");
    chk(trip == 1'b0, "R8 hold-off masks trip", trip, 0);
    hold_off = 1'b0;
    burst(400, 1, 1'b0, "R9 ref from masked");
    chk(trip == 1'b1, "R9 masked samples kept in history", trip, 1);

    // R10: cycle_start colliding with sample_done
    new_cycle("R10 collide");
    burst(800, 1, 1'b0, "R10 a");
    burst(800, 1, 1'b0, "R10 b");
    burst(700, 1, 1'b1, "R10 clear wins");
    chk(trip == 1'b0, "R10 clear beats completion", trip, 0);
    burst(650, 1, 1'b0, "R10 post-clear first");
    chk(trip == 1'b0, "R10 history emptied by clear", trip, 0);

    // R4: valid offered while idle is not consumed
    @(negedge clk) begin conv_valid = 1'b1; conv_code = 10'd1023; end
    repeat (5) @(negedge clk);
    conv_valid = 1'b0;
    chk(conv_ready == 1'b0, "R4 no ready while idle", conv_ready, 0);
    burst(500, 1, 1'b0, "R4 idle valid ignored");

    // constrained random
    for (int k = 0; k < 60; k++) begin
      if (($urandom % 8) == 0) new_cycle("rand");
      hold_off      = (($urandom % 5) == 0);
      cutoff_code   = CW'(150 + $urandom % 200);
      lowfault_code = CW'(700 + $urandom % 250);
      burst(300 + int'($urandom % 500), 1 + int'($urandom % 40),
            (($urandom % 10) == 0), "rand R6 R7 R8");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule